// File: doc/BRIEF.md
# User-Level Instruction Permission Gate

This block owns one 32-bit system control word and uses its fields to rule on instructions that the decoder hands over. For every decoded instruction it reports one of three outcomes: run it normally, trap it to the supervisor level, or treat it as undefined. Software above user level reads and writes the control word through a small system-register port. The block then presents the live field values and the data endianness selects for user and supervisor accesses to the rest of the core.

Some bit positions are fixed at zero or at one. Each writable field has its own reset value. The supervisor endianness field takes its reset value from a configuration strap. Decisions are made only for user-level instructions. Any user-level attempt to reach the control word through the port is itself trapped. The trap and undefined flags and the read data are registered, so each one appears in the cycle after the request is sampled.

Top module: `priv_trap_gate`

## Requirements
- R1: Bits 31, 30, 27, 21, 17, 13, 10 and 6 of `ctl_fields` always read 0, whatever is written.
- R2: Bits 29, 28, 23, 22, 20 and 11 of `ctl_fields` always read 1, whatever is written.
- R3: After a synchronous reset, `ctl_fields` equals 0x30D50838 with bit 25 copied from `boot_be` (so 0x32D50838 when the strap is 1).
- R4: A port write at level 1 or above stores the written data in all writable bits (26:24, 19:18, 16:14, 12, 9:7, 5:0) in the same clock edge. The new value drives the decisions for the next instruction. A port read at level 1 or above returns the current word on `csr_rdata` one cycle later. In every other cycle `csr_rdata` is 0.
- R5: A port read or write at level 0 (user) raises `trap_o` in the next cycle, leaves the word unchanged and returns 0 on `csr_rdata`.
- R6: A user instruction of class bit 0 (wait-for-event) traps when bit 18 is 0. A user instruction of class bit 1 (wait-for-interrupt) traps when bit 16 is 0. Either one runs normally when its bit is 1.
- R7: At user level, class bit 2 (cache zero by address) traps when bit 14 is 0, class bit 3 (cache clean/invalidate) traps when bit 26 is 0, and class bit 4 (cache-type read) traps when bit 15 is 0.
- R8: At user level, class bit 5 (endianness-set) raises `undef_o` when bit 8 is 1, and class bit 6 (legacy barrier) raises `undef_o` when bit 5 is 0. Class bit 7 (all other instructions) never raises a flag.
- R9: Instructions issued at levels 1, 2 or 3 never raise `trap_o` or `undef_o`.
- R10: `be_super` always equals bit 25 and `be_user` always equals bit 24 of the live word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_be | input | 1 | Strap giving the reset value of the supervisor endianness field |
| priv_lvl | input | 2 | Current exception level, 0 = user |
| csr_wr_en | input | 1 | Port write request |
| csr_rd_en | input | 1 | Port read request |
| csr_wdata | input | 32 | Port write data |
| csr_rdata | output | 32 | Registered port read data |
| insn_valid | input | 1 | Decoded instruction present |
| insn_class | input | 8 | One-hot instruction class |
| trap_o | output | 1 | Trap to supervisor, registered |
| undef_o | output | 1 | Undefined instruction, registered |
| ctl_fields | output | 32 | Live control word |
| be_user | output | 1 | User data endianness, 1 = big |
| be_super | output | 1 | Supervisor data endianness, 1 = big |

## Verification
The properties assume that `insn_class` has at most one bit set whenever `insn_valid` is high. They also assume that no instruction is issued in the same cycle as a port access, because a flag raised by the port would otherwise be mixed with a flag from the instruction decision. The stimulus follows both rules: each step drives either a single one-hot class or a single port operation, never both. The strap is changed only while reset is held.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int DW   = 32;
  localparam int NCLS = 8;

  // one-hot class positions, fixed by the decoder
  localparam int C_WFE    = 0;
  localparam int C_WFI    = 1;
  localparam int C_ZERO   = 2;
  localparam int C_CMAINT = 3;
  localparam int C_CTYPE  = 4;
  localparam int C_SETEND = 5;
  localparam int C_BARR   = 6;

  // field positions inside the control word
  localparam int F_CMAINT = 26;
  localparam int F_BESUP  = 25;
  localparam int F_BEUSR  = 24;
  localparam int F_WFE    = 18;
  localparam int F_WFI    = 16;
  localparam int F_CTYPE  = 15;
  localparam int F_ZERO   = 14;
  localparam int F_SETEND = 8;
  localparam int F_BARR   = 5;

  localparam logic [DW-1:0] ONES_MASK  = 32'h30D0_0800;
  localparam logic [DW-1:0] ZEROS_MASK = 32'hC822_2440;
  localparam logic [DW-1:0] WR_MASK    = ~(ONES_MASK | ZEROS_MASK);
  localparam logic [DW-1:0] RST_WORD   = 32'h30D5_0838;

  localparam logic [1:0] LVL_USER = 2'd0;
endpackage

// File: rtl/ptg_ctl_reg.sv
module ptg_ctl_reg
  import ptg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          strap,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word
);
  logic [DW-1:0] store;

  always_ff @(posedge clk) begin
    if (rst) begin
      store <= (RST_WORD & WR_MASK) | (DW'(strap) << F_BESUP);
    end else if (we) begin
      store <= wdata & WR_MASK;
    end
  end

  assign word = (store & WR_MASK) | ONES_MASK;
endmodule

// File: rtl/ptg_decide.sv
module ptg_decide
  import ptg_pkg::*;
(
  input  logic [DW-1:0]   word,
  input  logic            user,
  input  logic            valid,
  input  logic [NCLS-1:0] cls,
  output logic            trap_c,
  output logic            undef_c
);
  logic [NCLS-1:0] trap_on;
  logic [NCLS-1:0] undef_on;

  for (genvar i = 0; i < NCLS; i++) begin : g_cls
    if (i == C_WFE) begin : g_wfe
      assign trap_on[i] = ~word[F_WFE];   assign undef_on[i] = 1'b0;
    end else if (i == C_WFI) begin : g_wfi
      assign trap_on[i] = ~word[F_WFI];   assign undef_on[i] = 1'b0;
    end else if (i == C_ZERO) begin : g_zero
      assign trap_on[i] = ~word[F_ZERO];  assign undef_on[i] = 1'b0;
    end else if (i == C_CMAINT) begin : g_cm
      assign trap_on[i] = ~word[F_CMAINT]; assign undef_on[i] = 1'b0;
    end else if (i == C_CTYPE) begin : g_ct
      assign trap_on[i] = ~word[F_CTYPE]; assign undef_on[i] = 1'b0;
    end else if (i == C_SETEND) begin : g_se
      assign trap_on[i] = 1'b0;           assign undef_on[i] = word[F_SETEND];
    end else if (i == C_BARR) begin : g_bar
      assign trap_on[i] = 1'b0;           assign undef_on[i] = ~word[F_BARR];
    end else begin : g_none
      assign trap_on[i] = 1'b0;           assign undef_on[i] = 1'b0;
    end
  end

  assign trap_c  = user & valid & |(cls & trap_on);
  assign undef_c = user & valid & |(cls & undef_on);
endmodule

// File: rtl/priv_trap_gate.sv
module priv_trap_gate
  import ptg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            boot_be,
  input  logic [1:0]      priv_lvl,
  input  logic            csr_wr_en,
  input  logic            csr_rd_en,
  input  logic [DW-1:0]   csr_wdata,
  output logic [DW-1:0]   csr_rdata,
  input  logic            insn_valid,
  input  logic [NCLS-1:0] insn_class,
  output logic            trap_o,
  output logic            undef_o,
  output logic [DW-1:0]   ctl_fields,
  output logic            be_user,
  output logic            be_super
);
  logic is_user;
  logic wr_ok;
  logic port_trap;
  logic trap_c;
  logic undef_c;

  assign is_user   = (priv_lvl == LVL_USER);
  assign wr_ok     = csr_wr_en & ~is_user;
  assign port_trap = is_user & (csr_wr_en | csr_rd_en);

  ptg_ctl_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .strap (boot_be),
    .we    (wr_ok),
    .wdata (csr_wdata),
    .word  (ctl_fields)
  );

  ptg_decide u_dec (
    .word    (ctl_fields),
    .user    (is_user),
    .valid   (insn_valid),
    .cls     (insn_class),
    .trap_c  (trap_c),
    .undef_c (undef_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o    <= 1'b0;
      undef_o   <= 1'b0;
      csr_rdata <= '0;
    end else begin
      trap_o    <= trap_c | port_trap;
      undef_o   <= undef_c;
      csr_rdata <= (csr_rd_en && !is_user) ? ctl_fields : '0;
    end
  end

  assign be_user  = ctl_fields[F_BEUSR];
  assign be_super = ctl_fields[F_BESUP];
endmodule

// File: rtl/ptg_chk.sv
module ptg_chk
  import ptg_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            boot_be,
  input logic [1:0]      priv_lvl,
  input logic            csr_wr_en,
  input logic            csr_rd_en,
  input logic [DW-1:0]   csr_wdata,
  input logic            insn_valid,
  input logic [NCLS-1:0] insn_class,
  input logic            trap_o,
  input logic            undef_o,
  input logic [DW-1:0]   ctl_fields
);
  logic usr;
  logic port;
  assign usr  = (priv_lvl == LVL_USER);
  assign port = csr_wr_en | csr_rd_en;

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    (ctl_fields & ZEROS_MASK) == '0); // R1
  AST_ONE_BITS: assert property (@(posedge clk) disable iff (rst)
    (ctl_fields & ONES_MASK) == ONES_MASK); // R2
  AST_RESET_WORD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ctl_fields == (RST_WORD | (DW'($past(boot_be)) << F_BESUP))); // R3
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (csr_wr_en && !usr) |=> ctl_fields == (($past(csr_wdata) & WR_MASK) | ONES_MASK)); // R4
  AST_USER_PORT: assert property (@(posedge clk) disable iff (rst)
    (port && usr) |=> (trap_o && $stable(ctl_fields))); // R5
  AST_WFI_TRAP: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && usr && !port && insn_class[C_WFI] && !ctl_fields[F_WFI]) |=> trap_o); // R6
  AST_CMAINT_TRAP: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && usr && !port && insn_class[C_CMAINT] && !ctl_fields[F_CMAINT]) |=> trap_o); // R7
  AST_SETEND_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && usr && insn_class[C_SETEND] && ctl_fields[F_SETEND]) |=> undef_o); // R8
  AST_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!usr && !port) |=> (!trap_o && !undef_o)); // R9
endmodule

bind priv_trap_gate ptg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .boot_be    (boot_be),
  .priv_lvl   (priv_lvl),
  .csr_wr_en  (csr_wr_en),
  .csr_rd_en  (csr_rd_en),
  .csr_wdata  (csr_wdata),
  .insn_valid (insn_valid),
  .insn_class (insn_class),
  .trap_o     (trap_o),
  .undef_o    (undef_o),
  .ctl_fields (ctl_fields)
);

// File: tb/tb_priv_trap_gate.sv
module tb_priv_trap_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_be = 1'b0;
  logic [1:0]  priv_lvl = 2'd1;
  logic        csr_wr_en = 1'b0;
  logic        csr_rd_en = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        insn_valid = 1'b0;
  logic [7:0]  insn_class = '0;
  logic        trap_o, undef_o, be_user, be_super;
  logic [31:0] ctl_fields;

  always #2 clk = ~clk;

  priv_trap_gate dut (.*);

  typedef struct {
    logic        trap;
    logic        undef;
    logic [31:0] rdata;
    logic [31:0] word;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  logic [31:0] m;

  localparam logic [31:0] K1 = 32'h30D0_0800;
  localparam logic [31:0] KW = ~(32'h30D0_0800 | 32'hC822_2440);

  function automatic logic [1:0] rule(logic [31:0] w, int c);
    // {trap, undef} for a user instruction of class c
    case (c)
      0: return {~w[18], 1'b0};
      1: return {~w[16], 1'b0};
      2: return {~w[14], 1'b0};
      3: return {~w[26], 1'b0};
      4: return {~w[15], 1'b0};
      5: return {1'b0, w[8]};
      6: return {1'b0, ~w[5]};
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // driver: one step per cycle, pushes the expected result
  task automatic step(logic [1:0] lv, bit wr, bit rd, logic [31:0] wd, int cls, string tag);
    exp_t e;
    logic [1:0] tu;
    @(negedge clk);
    priv_lvl   = lv;
    csr_wr_en  = wr;
    csr_rd_en  = rd;
    csr_wdata  = wd;
    insn_valid = (cls >= 0);
    insn_class = (cls >= 0) ? (8'd1 << cls) : 8'd0;
    tu = (cls >= 0 && lv == 2'd0) ? rule(m, cls) : 2'b00;
    e.trap  = tu[1] | ((wr | rd) & (lv == 2'd0));
    e.undef = tu[0];
    e.rdata = (rd && lv != 2'd0) ? m : 32'd0;
    if (wr && lv != 2'd0) m = (wd & KW) | K1;
    e.word = m;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    csr_wr_en = 0; csr_rd_en = 0; insn_valid = 0; insn_class = '0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(trap_o == e.trap,   e.tag, "trap",  {31'd0, trap_o},  {31'd0, e.trap});
      check(undef_o == e.undef, e.tag, "undef", {31'd0, undef_o}, {31'd0, e.undef});
      check(csr_rdata == e.rdata, e.tag, "rdata", csr_rdata, e.rdata);
      check(ctl_fields == e.word, e.tag, "word",  ctl_fields, e.word);
      check(be_user == e.word[24] && be_super == e.word[25], "R10", "endian",
            {30'd0, be_super, be_user}, {30'd0, e.word[25], e.word[24]});
    end
  end

  task automatic do_reset(bit strap);
    @(negedge clk);
    rst = 1; boot_be = strap;
    csr_wr_en = 0; csr_rd_en = 0; insn_valid = 0; insn_class = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    m = 32'h30D5_0838 | (32'(strap) << 25);
    check(ctl_fields == m, "R3", "reset word", ctl_fields, m);
    check(trap_o == 0 && undef_o == 0 && csr_rdata == 0, "R3", "reset outputs",
          {30'd0, trap_o, undef_o}, 32'd0);
  endtask

  initial begin
    do_reset(1'b0);
    step(2'd1, 0, 1, '0, -1, "R4 read reset word");
    // user instructions with reset fields
    for (int c = 0; c < 8; c++) step(2'd0, 0, 0, '0, c, "R6 R7 R8 reset fields");
    // set every bit from supervisor
    step(2'd1, 1, 0, 32'hFFFF_FFFF, -1, "R1 R2 write ones");
    step(2'd1, 0, 1, '0, -1, "R4 read back ones");
    for (int c = 0; c < 8; c++) step(2'd0, 0, 0, '0, c, "R7 R8 all ones");
    // clear every bit from a higher level
    step(2'd2, 1, 0, 32'h0000_0000, -1, "R1 R2 write zeros");
    for (int c = 0; c < 8; c++) step(2'd0, 0, 0, '0, c, "R6 R8 all zeros");
    // higher levels stay quiet
    for (int c = 0; c < 8; c++) step(2'd1, 0, 0, '0, c, "R9 level1");
    for (int c = 0; c < 8; c++) step(2'd3, 0, 0, '0, c, "R9 level3");
    // user port access blocked
    step(2'd0, 1, 0, 32'hFFFF_FFFF, -1, "R5 user write");
    step(2'd0, 0, 1, '0, -1, "R5 user read");
    step(2'd3, 0, 1, '0, -1, "R5 word unchanged");
    // write then use next cycle
    step(2'd1, 1, 0, 32'h0001_0000, -1, "R4 enable wfi");
    step(2'd0, 0, 0, '0, 1, "R4 wfi uses new value");
    step(2'd0, 0, 0, '0, 0, "R6 wfe still traps");
    step(2'd1, 1, 1, 32'h0504_C120, -1, "R4 write with read");
    step(2'd1, 0, 1, '0, -1, "R4 read pattern");
    for (int c = 0; c < 8; c++) step(2'd0, 0, 0, '0, c, "R7 R8 pattern");
    idle();
    repeat (3) @(negedge clk);
    do_reset(1'b1);
    step(2'd1, 0, 1, '0, -1, "R3 R10 strap high");
    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule